// File: doc/BRIEF.md
# SPI Chip-Select Timing Sequencer

This block wraps every flash burst in a chip-select window with programmable timing. When a burst request is taken, it may first hold chip-select low for a programmable setup time before the data phase starts. It then signals the data-phase engine with a one-cycle start strobe and keeps chip-select low until that engine reports completion. After completion it may keep chip-select low for a programmable hold time. This hold is longer when the error-correction mode is on. Last, it keeps chip-select high for a programmable minimum gap before it takes the next request.

All counting uses the core clock. One serial-clock period is treated as one core cycle. The timing fields are captured when a request is taken. They stay in force until the burst's gap has ended. A synchronous clear input sends the sequencer back to idle at once from any phase.

Top module: `cs_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `cs_n`=1, `idle`=1 and `data_start`=0.
- R2: If a request is taken with `setup_en`=1, `cs_n` is 0 for `setup_cyc`+1 cycles before the cycle in which `data_start` is 1. `cs_n` stays 0 through that cycle.
- R3: If a request is taken with `setup_en`=0, `cs_n` goes to 0 and `data_start` is 1 in the first cycle after the accepting edge.
- R4: `data_start` is 1 for exactly one cycle, which is the first data-phase cycle. The data phase lasts up to and including the cycle in which `xfer_done` is sampled high. `xfer_done` has no effect outside the data phase.
- R5: If `hold_en`=1 and `ecc_mode`=0, `cs_n` stays 0 for `hold_cyc` cycles after the last data cycle.
- R6: If `hold_en`=1 and `ecc_mode`=1, `cs_n` stays 0 for `hold_cyc`+`ecc_hold_cyc` cycles after the last data cycle. A total of zero means no hold.
- R7: If `hold_en`=0, `cs_n` returns to 1 in the cycle right after the last data cycle.
- R8: After chip-select rises, `cs_n` stays 1 for at least `gap_cyc`+1 cycles. `req_ready` is 0 in every gap cycle except the last one. A request held during the gap is taken at the end of that last gap cycle, so back-to-back bursts are separated by exactly `gap_cyc`+1 high cycles.
- R9: Changes to any configuration input after the accepting edge have no effect on the burst already taken, including its gap.
- R10: If `fsm_clear` is 1 at a clock edge, the next cycle shows `idle`=1 and `cs_n`=1. `req_ready` is 0 while `fsm_clear` is 1.
- R11: `idle` is 1 exactly when no burst or gap is in progress. While idle, with `fsm_clear`=0, `req_ready` is 1. A request is taken on an edge where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsm_clear | input | 1 | Synchronous return to idle |
| req_valid | input | 1 | Burst request |
| req_ready | output | 1 | Request can be taken this cycle |
| xfer_done | input | 1 | Data phase complete strobe |
| setup_en | input | 1 | Enable setup phase |
| setup_cyc | input | 5 | Setup length minus one |
| hold_en | input | 1 | Enable hold phase |
| hold_cyc | input | 5 | Base hold length |
| ecc_mode | input | 1 | Error-correction mode, extends hold |
| ecc_hold_cyc | input | 3 | Extra hold length in ECC mode |
| gap_cyc | input | 6 | Minimum high gap minus one |
| cs_n | output | 1 | Active-low chip-select |
| data_start | output | 1 | One-cycle start of data phase |
| idle | output | 1 | Sequencer idle |

## Verification
A wrong phase or counter value shows up at `cs_n`, `data_start` and `req_ready` in the same cycle. A phase that ends one cycle early or late moves an edge of the chip-select window. A lost data-phase entry removes the start strobe. A gap counter that is off lets `req_ready` rise in the wrong cycle. Because every cycle of every burst is compared, such an error is reported in the first cycle where it differs. No error has to build up over several bursts before it can be seen. Configuration inputs are scrambled after acceptance to expose a field that is read live instead of from the captured copy.

// File: rtl/cs_seq_pkg.sv
// Shared types for the chip-select sequencer.
// Assumes: a single core clock drives every phase counter.
package cs_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_DATA  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_GAP   = 3'd4
    } seq_state_e;

    // Larger of two widths, used to size the shared phase counter.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cs_seq_cfg.sv
// Configuration capture for one burst.
// The live fields pass straight through on the accepting cycle, so the
// entry decision can use them. After that the captured copy is used until
// the next acceptance. The effective hold length is formed here.
module cs_seq_cfg #(
    parameter int SETUP_W = 5,
    parameter int HOLD_W  = 5,
    parameter int ECC_W   = 3,
    parameter int GAP_W   = 6,
    parameter int CNT_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic               in_setup_en,
    input  logic [SETUP_W-1:0] in_setup_cyc,
    input  logic               in_hold_en,
    input  logic [HOLD_W-1:0]  in_hold_cyc,
    input  logic               in_ecc_mode,
    input  logic [ECC_W-1:0]   in_ecc_hold,
    input  logic [GAP_W-1:0]   in_gap_cyc,
    output logic               eff_setup_en,
    output logic [SETUP_W-1:0] eff_setup_cyc,
    output logic               eff_hold_en,
    output logic [CNT_W-1:0]   eff_hold_len,
    output logic [GAP_W-1:0]   eff_gap_cyc
);
    logic               q_setup_en;
    logic [SETUP_W-1:0] q_setup_cyc;
    logic               q_hold_en;
    logic [HOLD_W-1:0]  q_hold_cyc;
    logic               q_ecc_mode;
    logic [ECC_W-1:0]   q_ecc_hold;
    logic [GAP_W-1:0]   q_gap_cyc;
    logic [HOLD_W-1:0]  sel_hold_cyc;
    logic               sel_ecc_mode;
    logic [ECC_W-1:0]   sel_ecc_hold;

    // Capture the fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_setup_en  <= 1'b0;
            q_setup_cyc <= '0;
            q_hold_en   <= 1'b0;
            q_hold_cyc  <= '0;
            q_ecc_mode  <= 1'b0;
            q_ecc_hold  <= '0;
            q_gap_cyc   <= '0;
        end else if (capture) begin
            q_setup_en  <= in_setup_en;
            q_setup_cyc <= in_setup_cyc;
            q_hold_en   <= in_hold_en;
            q_hold_cyc  <= in_hold_cyc;
            q_ecc_mode  <= in_ecc_mode;
            q_ecc_hold  <= in_ecc_hold;
            q_gap_cyc   <= in_gap_cyc;
        end
    end

    // Live fields on the accepting cycle, captured copy otherwise.
    always_comb begin
        eff_setup_en  = capture ? in_setup_en  : q_setup_en;
        eff_setup_cyc = capture ? in_setup_cyc : q_setup_cyc;
        eff_hold_en   = capture ? in_hold_en   : q_hold_en;
        sel_hold_cyc  = capture ? in_hold_cyc  : q_hold_cyc;
        sel_ecc_mode  = capture ? in_ecc_mode  : q_ecc_mode;
        sel_ecc_hold  = capture ? in_ecc_hold  : q_ecc_hold;
        eff_gap_cyc   = capture ? in_gap_cyc   : q_gap_cyc;
    end

    // Hold length: base count, plus the extra count in ECC mode.
    always_comb begin
        eff_hold_len = CNT_W'(sel_hold_cyc)
                     + (sel_ecc_mode ? CNT_W'(sel_ecc_hold) : CNT_W'(0));
    end

    // A burst in progress must see its captured fields.
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> (q_gap_cyc == $past(q_gap_cyc) && q_hold_en == $past(q_hold_en)));

endmodule

// File: rtl/cs_seq_timer.sv
// Shared phase down-counter.
// A load presets the value "phase length minus one". The counter then
// counts down to zero and stops there. `expired` marks the last cycle of
// the phase.
module cs_seq_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Preset on load, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    // Flag the final cycle of a phase.
    always_comb expired = (cnt == '0);

    // A preset of zero gives a one-cycle phase, and a non-zero preset does not.
    a_r2_reload_expire: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (expired == ($past(load_val) == '0)));

endmodule

// File: rtl/cs_seq_fsm.sv
// Phase controller: idle, setup, data, hold, gap.
// Assumes the timer is loaded on every entry to a timed phase. A request
// is taken in idle or in the final gap cycle. The clear input overrides
// every transition.
module cs_seq_fsm
    import cs_seq_pkg::*;
#(
    parameter int SETUP_W = 5,
    parameter int GAP_W   = 6,
    parameter int CNT_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               req_valid,
    input  logic               xfer_done,
    input  logic               expired,
    input  logic               setup_en,
    input  logic [SETUP_W-1:0] setup_cyc,
    input  logic               hold_en,
    input  logic [CNT_W-1:0]   hold_len,
    input  logic [GAP_W-1:0]   gap_cyc,
    output seq_state_e         state,
    output logic               req_ready,
    output logic               accept,
    output logic               load,
    output logic [CNT_W-1:0]   load_val,
    output logic               data_start
);
    seq_state_e nxt;

    // Request handshake.
    always_comb begin
        req_ready = !clear && (state == ST_IDLE || (state == ST_GAP && expired));
        accept    = req_ready && req_valid;
    end

    // Next phase and timer preset.
    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        if (accept) begin
            if (setup_en) begin
                nxt      = ST_SETUP;
                load     = 1'b1;
                load_val = CNT_W'(setup_cyc);
            end else begin
                nxt = ST_DATA;
            end
        end else begin
            case (state)
                ST_SETUP: if (expired) nxt = ST_DATA;
                ST_DATA: begin
                    if (xfer_done) begin
                        load = 1'b1;
                        if (hold_en && hold_len != '0) begin
                            nxt      = ST_HOLD;
                            load_val = hold_len - CNT_W'(1);
                        end else begin
                            nxt      = ST_GAP;
                            load_val = CNT_W'(gap_cyc);
                        end
                    end
                end
                ST_HOLD: begin
                    if (expired) begin
                        nxt      = ST_GAP;
                        load     = 1'b1;
                        load_val = CNT_W'(gap_cyc);
                    end
                end
                ST_GAP:  if (expired) nxt = ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
        if (clear) begin
            nxt  = ST_IDLE;
            load = 1'b0;
        end
    end

    // Phase register and data-start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            data_start <= 1'b0;
        end else begin
            state      <= nxt;
            data_start <= (nxt == ST_DATA) && (state != ST_DATA);
        end
    end

    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        data_start |=> !data_start);

    a_r4_start_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        data_start |-> state == ST_DATA);

    a_r3_skip_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !setup_en) |=> (state == ST_DATA && data_start));

    a_r7_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && xfer_done && !clear && !hold_en) |=> state == ST_GAP);

    a_r8_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP && !expired && !clear) |=> state == ST_GAP);

endmodule

// File: rtl/cs_sequencer.sv
// Chip-select timing sequencer, top level.
// It links the config capture, the phase controller and the shared timer.
// Chip-select is low in the setup, data and hold phases. All timing is
// counted in core cycles.
module cs_sequencer
    import cs_seq_pkg::*;
#(
    parameter int SETUP_W = 5,
    parameter int HOLD_W  = 5,
    parameter int ECC_W   = 3,
    parameter int GAP_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fsm_clear,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               xfer_done,
    input  logic               setup_en,
    input  logic [SETUP_W-1:0] setup_cyc,
    input  logic               hold_en,
    input  logic [HOLD_W-1:0]  hold_cyc,
    input  logic               ecc_mode,
    input  logic [ECC_W-1:0]   ecc_hold_cyc,
    input  logic [GAP_W-1:0]   gap_cyc,
    output logic               cs_n,
    output logic               data_start,
    output logic               idle
);
    localparam int SUM_W = max2(HOLD_W, ECC_W) + 1;
    localparam int CNT_W = max2(max2(SETUP_W, GAP_W), SUM_W);

    seq_state_e         state;
    logic               accept;
    logic               load;
    logic [CNT_W-1:0]   load_val;
    logic               expired;
    logic               e_setup_en;
    logic [SETUP_W-1:0] e_setup_cyc;
    logic               e_hold_en;
    logic [CNT_W-1:0]   e_hold_len;
    logic [GAP_W-1:0]   e_gap_cyc;

    cs_seq_cfg #(
        .SETUP_W(SETUP_W), .HOLD_W(HOLD_W), .ECC_W(ECC_W),
        .GAP_W(GAP_W), .CNT_W(CNT_W)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (accept),
        .in_setup_en  (setup_en),
        .in_setup_cyc (setup_cyc),
        .in_hold_en   (hold_en),
        .in_hold_cyc  (hold_cyc),
        .in_ecc_mode  (ecc_mode),
        .in_ecc_hold  (ecc_hold_cyc),
        .in_gap_cyc   (gap_cyc),
        .eff_setup_en (e_setup_en),
        .eff_setup_cyc(e_setup_cyc),
        .eff_hold_en  (e_hold_en),
        .eff_hold_len (e_hold_len),
        .eff_gap_cyc  (e_gap_cyc)
    );

    cs_seq_fsm #(
        .SETUP_W(SETUP_W), .GAP_W(GAP_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (fsm_clear),
        .req_valid (req_valid),
        .xfer_done (xfer_done),
        .expired   (expired),
        .setup_en  (e_setup_en),
        .setup_cyc (e_setup_cyc),
        .hold_en   (e_hold_en),
        .hold_len  (e_hold_len),
        .gap_cyc   (e_gap_cyc),
        .state     (state),
        .req_ready (req_ready),
        .accept    (accept),
        .load      (load),
        .load_val  (load_val),
        .data_start(data_start)
    );

    cs_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(load_val),
        .expired (expired)
    );

    // Chip-select and idle flag decoded from the phase register.
    always_comb begin
        cs_n = !(state == ST_SETUP || state == ST_DATA || state == ST_HOLD);
        idle = (state == ST_IDLE);
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (cs_n && idle && !data_start));

    a_r10_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_clear |=> (idle && cs_n));

    a_r10_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_clear |-> !req_ready);

    a_r11_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !fsm_clear) |-> req_ready);

endmodule

// File: tb/cs_sequencer_test.sv
// Bench for the chip-select sequencer. For each burst the expected cycle
// window is computed from the field values, and the outputs are compared
// on every cycle.
module cs_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsm_clear = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       xfer_done = 1'b0;
    logic       setup_en = 1'b0;
    logic [4:0] setup_cyc = '0;
    logic       hold_en = 1'b0;
    logic [4:0] hold_cyc = '0;
    logic       ecc_mode = 1'b0;
    logic [2:0] ecc_hold_cyc = '0;
    logic [5:0] gap_cyc = '0;
    logic       cs_n;
    logic       data_start;
    logic       idle;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cs_sequencer uut (
        .clk(clk), .rst_n(rst_n), .fsm_clear(fsm_clear),
        .req_valid(req_valid), .req_ready(req_ready), .xfer_done(xfer_done),
        .setup_en(setup_en), .setup_cyc(setup_cyc), .hold_en(hold_en),
        .hold_cyc(hold_cyc), .ecc_mode(ecc_mode), .ecc_hold_cyc(ecc_hold_cyc),
        .gap_cyc(gap_cyc), .cs_n(cs_n), .data_start(data_start), .idle(idle)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Issue one burst at a negedge where the sequencer can take it. The task
    // returns at the negedge of the final gap cycle.
    task automatic burst(input bit se, input int s, input bit he, input int h,
                         input bit ec, input int e, input int g, input int d,
                         input bit noise, input bit scramble, input bit pend);
        int hl, hold, ds, len, last;
        string tg;
        hl   = h + (ec ? e : 0);
        hold = (he && hl > 0) ? hl : 0;
        ds   = se ? s + 2 : 1;
        len  = ds - 1 + d + hold;
        last = len + g + 1;
        chk("R11", "req_ready before request", req_ready, 1'b1);
        req_valid = 1'b1; xfer_done = 1'b0;
        setup_en = se; setup_cyc = 5'(s); hold_en = he; hold_cyc = 5'(h);
        ecc_mode = ec; ecc_hold_cyc = 3'(e); gap_cyc = 6'(g);
        step();
        req_valid = 1'b0;
        if (scramble) begin
            // R9: every field changes right after acceptance.
            setup_en = !se; setup_cyc = ~setup_cyc; hold_en = !he; hold_cyc = ~hold_cyc;
            ecc_mode = !ec; ecc_hold_cyc = ~ecc_hold_cyc; gap_cyc = ~gap_cyc;
        end
        for (int k = 1; k <= last; k++) begin
            if (scramble)             tg = "R9";
            else if (k < ds)          tg = "R2";
            else if (k == 1)          tg = "R3";
            else if (k < ds + d)      tg = "R4";
            else if (k <= len)        tg = ec ? "R6" : "R5";
            else if (!he && k == len + 1) tg = "R7";
            else                      tg = "R8";
            chk(tg, "cs_n", cs_n, (k <= len) ? 1'b0 : 1'b1);
            chk(tg, "data_start", data_start, (k == ds) ? 1'b1 : 1'b0);
            chk(tg, "req_ready", req_ready, (k == last) ? 1'b1 : 1'b0);
            chk("R11", "idle in burst", idle, 1'b0);
            if (k == ds + d - 1)
                xfer_done = 1'b1;
            else
                xfer_done = (noise && (k < ds || k >= ds + d)) ? 1'b1 : 1'b0;
            req_valid = (pend && k > len && k < last) ? 1'b1 : 1'b0;
            if (k < last) step();
        end
    endtask

    task automatic settle(input int n);
        req_valid = 1'b0; xfer_done = 1'b0;
        for (int i = 0; i < n; i++) begin
            step();
            chk("R11", "idle", idle, 1'b1);
            chk("R11", "req_ready idle", req_ready, 1'b1);
            chk("R8", "cs_n after gap", cs_n, 1'b1);
            chk("R4", "data_start idle", data_start, 1'b0);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        chk("R1", "cs_n in reset", cs_n, 1'b1);
        chk("R1", "idle in reset", idle, 1'b1);
        chk("R1", "data_start in reset", data_start, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R11", "idle after reset", idle, 1'b1);
        chk("R11", "ready after reset", req_ready, 1'b1);

        // Every mix of setup enable, hold enable and ECC mode.
        for (int m = 0; m < 8; m++) begin
            burst(m[0], 3, m[1], 4, m[2], 2, 2, 3, m[0] ^ m[1], 1'b0, 1'b0);
            settle(2);
        end

        // Back-to-back bursts with edge values and a request held in the gap.
        burst(1'b1, 0, 1'b1, 0, 1'b1, 3, 0, 1, 1'b0, 1'b0, 1'b1);
        burst(1'b0, 5, 1'b1, 0, 1'b0, 0, 4, 2, 1'b1, 1'b0, 1'b1);
        burst(1'b1, 31, 1'b1, 31, 1'b1, 7, 63, 1, 1'b0, 1'b1, 1'b1);
        burst(1'b0, 0, 1'b0, 9, 1'b0, 0, 1, 4, 1'b1, 1'b1, 1'b0);
        settle(1);

        // R10: clear in the middle of the data phase.
        req_valid = 1'b1; setup_en = 1'b1; setup_cyc = 5'd2; hold_en = 1'b1;
        hold_cyc = 5'd3; ecc_mode = 1'b0; gap_cyc = 6'd5; xfer_done = 1'b0;
        step();
        req_valid = 1'b0;
        repeat (4) step();
        chk("R10", "cs_n before clear", cs_n, 1'b0);
        fsm_clear = 1'b1;
        #1 chk("R10", "ready during clear", req_ready, 1'b0);
        step();
        chk("R10", "idle after clear", idle, 1'b1);
        chk("R10", "cs_n after clear", cs_n, 1'b1);
        chk("R10", "data_start after clear", data_start, 1'b0);
        fsm_clear = 1'b0;
        #1 chk("R10", "ready after clear", req_ready, 1'b1);
        burst(1'b0, 0, 1'b1, 2, 1'b1, 1, 3, 2, 1'b0, 1'b0, 1'b0);
        settle(2);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule